// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter

This block connects an 8-bit host bus to two independent 8-bit peripheral ports, A and B. Every pin of a port is set as input or output by its own bit in that port's direction register. Each port also has a control register and two control lines. The first line of each port is an edge-sensitive input. The second line is either a second edge input or a strobe output. Each port drives its own interrupt request.

The host reaches six registers through a two-bit register select. The device is selected by a three-bit chip-select pattern. An access takes effect on the clock cycle in which the enable strobe is seen low after having been high.

The two ports handshake asymmetrically:
- **Port A** is geared to input transfers. Its strobe falls when the host reads A's data.
- **Port B** is geared to output transfers. Its strobe falls when the host writes B's data.

In handshake mode the strobe is released by the next active edge on the port's first control line. In pulse mode it is released after a fixed number of cycles.

Top module: `pia_dual`

## Requirements
- R1: After reset, every control, direction and output register is zero. Both ports are all inputs (`pa_oe`/`pb_oe` zero), `irq_a`/`irq_b` are low, and the second control lines are undriven (`*2_oe` low) with their output values high.
- R2: Access to the block requires:
  - `csel` equal to `CS_MATCH` (default 3'b011);
  - an access commits in the cycle where `en` is sampled low after being high.
  
  While unselected, writes change nothing and `rdata` reads 0.
- R3: Addressing and register layout:
  - `reg_sel[1]` picks the port (0 = A, 1 = B).
  - `reg_sel[0]` picks the control register (1) or the data location (0).
  - Control bit 2 steers the data location to the direction register (0) or to the output register (1).
  - Writes to a control register change only bits 5:0. Bits 7:6 are status flags.
- R4: `pa_oe`/`pb_oe` equal the direction register, and `pa_out`/`pb_out` equal the output register.
- R5: A data read with control bit 2 set returns the pin value for bits whose direction bit is 0, and the output register value for bits whose direction bit is 1.
- R6: Control bit 7 sets on an active edge of the first line; bit 1 chooses the edge (1 rising, 0 falling). When bit 5 is 0, bit 6 sets on an active edge of the second line, with bit 4 choosing the edge. The flag is visible after the first clock edge that samples the new level.
- R7: Both flags clear when a committed read of the same port's data location occurs with bit 2 set. Reading the control register does not clear them.
- R8: The interrupt output is high exactly when (bit 7 and bit 0) or (bit 6 and bit 3 with bit 5 clear).
- R9: With bit 5 set, the second line is driven (`*2_oe` high). Bits 4:3 select the output mode:
  - 10: held low;
  - 11: held high.
  
  Both levels apply one cycle after the control write commits.
- R10: In port A handshake mode (bits 5:3 = 100), `ca2_out` falls after a committed read of A's output location. It rises on the next active edge of `ca1`. Writes to A's data do not start it.
- R11: In port B handshake mode (bits 5:3 = 100), `cb2_out` falls after a committed write of B's output location. It rises on the next active edge of `cb1`. Reads of B's data do not start it.
- R12: In pulse mode (bits 5:3 = 101), the strobe stays low for exactly `PULSE_CYC` cycles after the triggering access and then returns high.
- R13: While bit 5 is set, bit 6 reads 0 and is never set. Writing bit 5 as 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csel | input | 3 | Chip-select inputs, matched against CS_MATCH |
| reg_sel | input | 2 | Register select: [1] port, [0] control/data |
| rd | input | 1 | 1 = read, 0 = write |
| en | input | 1 | Bus enable strobe; access commits on its fall |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B per-pin output enable |
| ca1 | input | 1 | Port A first control line (edge input) |
| ca2_in | input | 1 | Port A second control line, input level |
| ca2_out | output | 1 | Port A second control line, output value |
| ca2_oe | output | 1 | Port A second control line, drive enable |
| cb1 | input | 1 | Port B first control line (edge input) |
| cb2_in | input | 1 | Port B second control line, input level |
| cb2_out | output | 1 | Port B second control line, output value |
| cb2_oe | output | 1 | Port B second control line, drive enable |
| irq_a | output | 1 | Port A interrupt request, active high |
| irq_b | output | 1 | Port B interrupt request, active high |

## Verification
The assertions that tie strobe falls to a particular access type, and the one on unselected cycles, assume the following about the host:
- `csel`, `reg_sel`, `rd` and `wdata` are stable from the rise of `en` through the cycle in which `en` is seen low;
- `en` stays high for at least one full cycle between accesses.

Under these conditions, two commits never fall on adjacent cycles, and a strobe change can be traced to one access. The bench's bus task enforces this. It sets all address and control inputs together with `en` at a falling clock edge, holds them one cycle, and drops `en` for the commit cycle. It drives chip-select inactive between accesses, and it drives peripheral lines only at falling clock edges.

// File: rtl/pia_pkg.sv
package pia_pkg;

    localparam int PORT_W = 8;

    // Control register layout, bit 7 first
    typedef struct packed {
        logic f1;        // first-line edge flag
        logic f2;        // second-line edge flag
        logic l2_drv;    // second line is an output
        logic m1;        // output mode high bit / input edge select
        logic m0;        // output mode low bit / input irq enable
        logic to_io;     // data location reaches output register
        logic l1_rise;   // first line active on rising edge
        logic l1_ien;    // first line irq enable
    } ctl_t;

    typedef enum logic [1:0] {
        L2_HANDSHAKE = 2'b00,
        L2_PULSE     = 2'b01,
        L2_FIX_LO    = 2'b10,
        L2_FIX_HI    = 2'b11
    } l2_mode_e;

    typedef enum logic {
        TRIG_ON_READ  = 1'b0,
        TRIG_ON_WRITE = 1'b1
    } trig_e;

    function automatic logic edge_hit(input logic now, input logic prev, input logic rise);
        return rise ? (now & ~prev) : (~now & prev);
    endfunction

    function automatic logic [PORT_W-1:0] merge_io(input logic [PORT_W-1:0] pins,
                                                   input logic [PORT_W-1:0] dir,
                                                   input logic [PORT_W-1:0] outr);
        return (pins & ~dir) | (outr & dir);
    endfunction

endpackage

// File: rtl/pia_edge.sv
module pia_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic rise,
    output logic hit
);
    import pia_pkg::*;

    logic prev;

    always_ff @(posedge clk) begin
        prev <= lvl;
    end

    assign hit = ~rst & edge_hit(lvl, prev, rise);

endmodule

// File: rtl/pia_strobe.sv
module pia_strobe #(
    parameter int PULSE_CYC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                drive_en,
    input  pia_pkg::l2_mode_e   mode,
    input  logic                trig,
    input  logic                release_hit,
    output logic                line
);
    import pia_pkg::*;

    localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= 1'b1;
            cnt  <= '0;
        end else if (!drive_en) begin
            line <= 1'b1;
            cnt  <= '0;
        end else begin
            unique case (mode)
                L2_HANDSHAKE: begin
                    if (trig)             line <= 1'b0;
                    else if (release_hit) line <= 1'b1;
                end
                L2_PULSE: begin
                    if (trig) begin
                        line <= 1'b0;
                        cnt  <= CW'(PULSE_CYC - 1);
                    end else if (!line) begin
                        if (cnt == '0) line <= 1'b1;
                        else           cnt  <= cnt - 1'b1;
                    end
                end
                L2_FIX_LO: line <= 1'b0;
                L2_FIX_HI: line <= 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pia_port.sv
module pia_port #(
    parameter int              PULSE_CYC = 4,
    parameter pia_pkg::trig_e  TRIG      = pia_pkg::TRIG_ON_READ
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc,
    input  logic                        acc_rd,
    input  logic                        addr_ctl,
    input  logic [pia_pkg::PORT_W-1:0]  wdata,
    input  logic [pia_pkg::PORT_W-1:0]  pin_in,
    input  logic                        l1,
    input  logic                        l2_in,
    output logic [pia_pkg::PORT_W-1:0]  rd_val,
    output logic [pia_pkg::PORT_W-1:0]  pin_out,
    output logic [pia_pkg::PORT_W-1:0]  pin_oe,
    output logic                        l2_out,
    output logic                        l2_oe,
    output logic                        irq,
    output pia_pkg::ctl_t               ctl_view
);
    import pia_pkg::*;

    logic [5:0]        cfg;
    logic              f1, f2;
    logic [PORT_W-1:0] dir_r, out_r;
    logic              hit1, hit2;
    logic              data_acc, io_rd, io_wr, ctl_wr, trig;

    assign ctl_view = ctl_t'({f1, f2, cfg});

    assign data_acc = acc & ~addr_ctl;
    assign io_rd    = data_acc & ctl_view.to_io & acc_rd;
    assign io_wr    = data_acc & ctl_view.to_io & ~acc_rd;
    assign ctl_wr   = acc & addr_ctl & ~acc_rd;

    generate
        if (TRIG == TRIG_ON_READ) begin : g_trig_rd
            assign trig = io_rd;
        end else begin : g_trig_wr
            assign trig = io_wr;
        end
    endgenerate

    pia_edge u_edge1 (
        .clk  (clk),
        .rst  (rst),
        .lvl  (l1),
        .rise (ctl_view.l1_rise),
        .hit  (hit1)
    );

    pia_edge u_edge2 (
        .clk  (clk),
        .rst  (rst),
        .lvl  (l2_in),
        .rise (ctl_view.m1),
        .hit  (hit2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            f1    <= 1'b0;
            f2    <= 1'b0;
            dir_r <= '0;
            out_r <= '0;
        end else begin
            if (ctl_wr) cfg <= wdata[5:0];
            if (data_acc && !acc_rd) begin
                if (ctl_view.to_io) out_r <= wdata;
                else                dir_r <= wdata;
            end
            f1 <= hit1 | (f1 & ~io_rd);
            if (ctl_wr && wdata[5]) f2 <= 1'b0;
            else                    f2 <= (hit2 & ~ctl_view.l2_drv) | (f2 & ~io_rd);
        end
    end

    always_comb begin
        if (addr_ctl)            rd_val = ctl_view;
        else if (ctl_view.to_io) rd_val = merge_io(pin_in, dir_r, out_r);
        else                     rd_val = dir_r;
    end

    pia_strobe #(.PULSE_CYC(PULSE_CYC)) u_strobe (
        .clk         (clk),
        .rst         (rst),
        .drive_en    (ctl_view.l2_drv),
        .mode        (l2_mode_e'({ctl_view.m1, ctl_view.m0})),
        .trig        (trig),
        .release_hit (hit1),
        .line        (l2_out)
    );

    assign pin_out = out_r;
    assign pin_oe  = dir_r;
    assign l2_oe   = ctl_view.l2_drv;
    assign irq     = (f1 & ctl_view.l1_ien) | (f2 & ctl_view.m0 & ~ctl_view.l2_drv);

endmodule

// File: rtl/pia_dual.sv
module pia_dual #(
    parameter logic [2:0] CS_MATCH  = 3'b011,
    parameter int         PULSE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] csel,
    input  logic [1:0] reg_sel,
    input  logic       rd,
    input  logic       en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] pa_in,
    output logic [7:0] pa_out,
    output logic [7:0] pa_oe,
    input  logic [7:0] pb_in,
    output logic [7:0] pb_out,
    output logic [7:0] pb_oe,
    input  logic       ca1,
    input  logic       ca2_in,
    output logic       ca2_out,
    output logic       ca2_oe,
    input  logic       cb1,
    input  logic       cb2_in,
    output logic       cb2_out,
    output logic       cb2_oe,
    output logic       irq_a,
    output logic       irq_b
);
    import pia_pkg::*;

    localparam int NPORT = 2;

    logic              en_q, sel, commit;
    logic [PORT_W-1:0] pin_in_v  [NPORT];
    logic [PORT_W-1:0] pin_out_v [NPORT];
    logic [PORT_W-1:0] pin_oe_v  [NPORT];
    logic [PORT_W-1:0] rd_val_v  [NPORT];
    logic              l1_v      [NPORT];
    logic              l2_in_v   [NPORT];
    logic              l2_out_v  [NPORT];
    logic              l2_oe_v   [NPORT];
    logic              irq_v     [NPORT];
    ctl_t              view_v    [NPORT];
    ctl_t              ctl_a, ctl_b;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en;
    end

    assign sel    = (csel == CS_MATCH);
    assign commit = sel & en_q & ~en;

    assign pin_in_v[0] = pa_in;
    assign pin_in_v[1] = pb_in;
    assign l1_v[0]     = ca1;
    assign l1_v[1]     = cb1;
    assign l2_in_v[0]  = ca2_in;
    assign l2_in_v[1]  = cb2_in;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            pia_port #(
                .PULSE_CYC (PULSE_CYC),
                .TRIG      ((p == 0) ? TRIG_ON_READ : TRIG_ON_WRITE)
            ) u_port (
                .clk      (clk),
                .rst      (rst),
                .acc      (commit && (reg_sel[1] == p[0])),
                .acc_rd   (rd),
                .addr_ctl (reg_sel[0]),
                .wdata    (wdata),
                .pin_in   (pin_in_v[p]),
                .l1       (l1_v[p]),
                .l2_in    (l2_in_v[p]),
                .rd_val   (rd_val_v[p]),
                .pin_out  (pin_out_v[p]),
                .pin_oe   (pin_oe_v[p]),
                .l2_out   (l2_out_v[p]),
                .l2_oe    (l2_oe_v[p]),
                .irq      (irq_v[p]),
                .ctl_view (view_v[p])
            );
        end
    endgenerate

    assign rdata   = sel ? rd_val_v[reg_sel[1]] : '0;
    assign pa_out  = pin_out_v[0];
    assign pa_oe   = pin_oe_v[0];
    assign pb_out  = pin_out_v[1];
    assign pb_oe   = pin_oe_v[1];
    assign ca2_out = l2_out_v[0];
    assign ca2_oe  = l2_oe_v[0];
    assign cb2_out = l2_out_v[1];
    assign cb2_oe  = l2_oe_v[1];
    assign irq_a   = irq_v[0];
    assign irq_b   = irq_v[1];
    assign ctl_a   = view_v[0];
    assign ctl_b   = view_v[1];

endmodule

// File: rtl/pia_dual_chk.sv
module pia_dual_chk #(
    parameter logic [2:0] CS_MATCH = 3'b011
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    csel,
    input logic [1:0]    reg_sel,
    input logic          rd,
    input logic          en,
    input logic [7:0]    pa_oe,
    input logic [7:0]    pb_oe,
    input logic [7:0]    pa_out,
    input logic [7:0]    pb_out,
    input logic          ca2_out,
    input logic          cb2_out,
    input logic          ca2_oe,
    input logic          cb2_oe,
    input logic          irq_a,
    input logic          irq_b,
    input pia_pkg::ctl_t ctl_a,
    input pia_pkg::ctl_t ctl_b
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (pa_oe == '0 && pb_oe == '0 && !irq_a && !irq_b &&
                 ca2_out && cb2_out && !ca2_oe && !cb2_oe)); // R1

    AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (csel != CS_MATCH) |=> ($stable(pa_oe) && $stable(pb_oe) &&
                                $stable(pa_out) && $stable(pb_out))); // R2

    AST_IRQ_A_SRC: assert property (@(posedge clk) disable iff (rst)
        irq_a |-> ((ctl_a.f1 && ctl_a.l1_ien) ||
                   (ctl_a.f2 && ctl_a.m0 && !ctl_a.l2_drv))); // R8

    AST_IRQ_B_SRC: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> ((ctl_b.f1 && ctl_b.l1_ien) ||
                   (ctl_b.f2 && ctl_b.m0 && !ctl_b.l2_drv))); // R8

    AST_A_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (csel == CS_MATCH && $past(en) && !en && !rd && reg_sel == 2'b00)
        |=> !$fell(ca2_out)); // R10

    AST_B_READ_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (csel == CS_MATCH && $past(en) && !en && rd && reg_sel == 2'b10)
        |=> !$fell(cb2_out)); // R11

    AST_F2_A_OUTMODE: assert property (@(posedge clk) disable iff (rst)
        ctl_a.l2_drv |-> !ctl_a.f2); // R13

    AST_F2_B_OUTMODE: assert property (@(posedge clk) disable iff (rst)
        ctl_b.l2_drv |-> !ctl_b.f2); // R13

endmodule

bind pia_dual pia_dual_chk #(.CS_MATCH(CS_MATCH)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .csel    (csel),
    .reg_sel (reg_sel),
    .rd      (rd),
    .en      (en),
    .pa_oe   (pa_oe),
    .pb_oe   (pb_oe),
    .pa_out  (pa_out),
    .pb_out  (pb_out),
    .ca2_out (ca2_out),
    .cb2_out (cb2_out),
    .ca2_oe  (ca2_oe),
    .cb2_oe  (cb2_oe),
    .irq_a   (irq_a),
    .irq_b   (irq_b),
    .ctl_a   (ctl_a),
    .ctl_b   (ctl_b)
);

// File: tb/test_pia_dual.sv
module test_pia_dual;

    localparam int         CLK_PERIOD = 10;
    localparam logic [2:0] CS_OK      = 3'b011;
    localparam int         P          = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] csel = 3'b000;
    logic [1:0] reg_sel = 2'b00;
    logic       rd = 1'b0;
    logic       en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
    logic       ca1 = 1'b0, ca2_in = 1'b0, cb1 = 1'b0, cb2_in = 1'b0;
    logic       ca2_out, ca2_oe, cb2_out, cb2_oe, irq_a, irq_b;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] q;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pia_dual #(.CS_MATCH(CS_OK), .PULSE_CYC(P)) i_pia_dual (
        .clk(clk), .rst(rst), .csel(csel), .reg_sel(reg_sel), .rd(rd), .en(en),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .ca1(ca1), .ca2_in(ca2_in), .ca2_out(ca2_out), .ca2_oe(ca2_oe),
        .cb1(cb1), .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    function automatic logic [7:0] exp_read(logic [7:0] pins, logic [7:0] dir, logic [7:0] outr);
        return (pins & ~dir) | (outr & dir);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus(input logic [2:0] cs, input logic [1:0] rs, input logic is_rd,
                       input logic [7:0] d, output logic [7:0] data_q);
        @(negedge clk);
        csel = cs; reg_sel = rs; rd = is_rd; wdata = d; en = 1'b1;
        @(negedge clk);
        data_q = rdata;
        en = 1'b0;
        @(negedge clk);
        csel = 3'b000;
    endtask

    task automatic wr(input logic [1:0] rs, input logic [7:0] d);
        logic [7:0] dummy;
        bus(CS_OK, rs, 1'b0, d, dummy);
    endtask

    task automatic rdr(input logic [1:0] rs, output logic [7:0] data_q);
        bus(CS_OK, rs, 1'b1, 8'h00, data_q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 irq", {irq_a, irq_b}, 2'b00);
        chk("R1 l2 lines", {ca2_out, ca2_oe, cb2_out, cb2_oe}, 4'b1010);
        rdr(2'b01, q); chk("R1 ctl A", q, 8'h00);
        rdr(2'b11, q); chk("R1 ctl B", q, 8'h00);

        // R2 unselected access is ignored and reads 0
        bus(3'b111, 2'b00, 1'b0, 8'hFF, q);
        chk("R2 unselected write", pa_oe, 8'h00);
        bus(3'b010, 2'b10, 1'b0, 8'hFF, q);
        chk("R2 unselected write B", pb_oe, 8'h00);
        bus(3'b111, 2'b01, 1'b1, 8'h00, q);
        chk("R2 unselected read", q, 8'h00);

        // R3 control write masks bits 7:6
        wr(2'b01, 8'hFF);
        rdr(2'b01, q); chk("R3 ctl mask", q, 8'h3F);
        wr(2'b01, 8'h00);
        tick();

        // R3/R4 direction vs output register
        wr(2'b00, 8'hA5);
        chk("R4 dir A", pa_oe, 8'hA5);
        rdr(2'b00, q); chk("R3 dir readback", q, 8'hA5);
        wr(2'b01, 8'h04);
        wr(2'b00, 8'h3C);
        chk("R4 out A", pa_out, 8'h3C);
        chk("R3 dir untouched", pa_oe, 8'hA5);

        // R4/R5 random patterns on both ports
        for (int i = 0; i < 30; i++) begin
            automatic logic       p    = 1'($urandom % 2);
            automatic logic [7:0] dir  = 8'($urandom);
            automatic logic [7:0] outv = 8'($urandom);
            automatic logic [7:0] pins = 8'($urandom);
            wr({p, 1'b1}, 8'h00);
            wr({p, 1'b0}, dir);
            wr({p, 1'b1}, 8'h04);
            wr({p, 1'b0}, outv);
            if (p) pb_in = pins; else pa_in = pins;
            rdr({p, 1'b0}, q);
            chk("R5 merged read", q, exp_read(pins, dir, outv));
            chk("R4 oe", p ? pb_oe : pa_oe, dir);
            chk("R4 out", p ? pb_out : pa_out, outv);
        end

        // R6/R7/R8 first-line flag, rising edge, irq enabled
        wr(2'b01, 8'h07);
        rdr(2'b00, q);
        ca1 = 1'b1; tick();
        rdr(2'b01, q); chk("R6 rising flag", q[7], 1'b1);
        chk("R8 irq_a set", irq_a, 1'b1);
        rdr(2'b01, q); chk("R7 ctl read keeps flag", q[7], 1'b1);
        rdr(2'b00, q);
        chk("R7 irq_a cleared", irq_a, 1'b0);
        rdr(2'b01, q); chk("R7 flag cleared", q[7], 1'b0);

        // falling edge selected, irq disabled
        wr(2'b01, 8'h04);
        ca1 = 1'b0; tick();
        rdr(2'b01, q); chk("R6 falling flag", q[7], 1'b1);
        chk("R8 irq masked", irq_a, 1'b0);
        rdr(2'b00, q);
        ca1 = 1'b1; tick();
        rdr(2'b01, q); chk("R6 wrong edge ignored", q[7], 1'b0);
        ca1 = 1'b0; tick();
        rdr(2'b00, q);

        // second line as input on port B
        wr(2'b11, 8'h1C);
        cb2_in = 1'b1; tick();
        rdr(2'b11, q); chk("R6 line2 flag", q[6], 1'b1);
        chk("R8 irq_b line2", irq_b, 1'b1);
        wr(2'b11, 8'h3C);
        rdr(2'b11, q); chk("R13 flag cleared by output mode", q[6], 1'b0);
        chk("R8 irq_b off", irq_b, 1'b0);
        chk("R9 cb2_oe", cb2_oe, 1'b1);
        cb2_in = 1'b0; tick();
        cb2_in = 1'b1; tick();
        rdr(2'b11, q); chk("R13 no flag in output mode", q[6], 1'b0);

        // R9 fixed levels on port A
        wr(2'b01, 8'h34); tick();
        chk("R9 fixed low", {ca2_oe, ca2_out}, 2'b10);
        wr(2'b01, 8'h3C); tick();
        chk("R9 fixed high", {ca2_oe, ca2_out}, 2'b11);

        // R10 port A read handshake
        wr(2'b01, 8'h26);
        tick();
        chk("R10 idle high", ca2_out, 1'b1);
        wr(2'b00, 8'h11);
        chk("R10 write no strobe", ca2_out, 1'b1);
        rdr(2'b00, q);
        chk("R10 strobe low after read", ca2_out, 1'b0);
        tick();
        chk("R10 strobe held", ca2_out, 1'b0);
        ca1 = 1'b1; tick();
        chk("R10 release on ca1", ca2_out, 1'b1);

        // R11 port B write handshake
        wr(2'b11, 8'h26);
        tick();
        rdr(2'b10, q);
        chk("R11 read no strobe", cb2_out, 1'b1);
        wr(2'b10, 8'h55);
        chk("R11 strobe low after write", cb2_out, 1'b0);
        chk("R4 out B", pb_out, 8'h55);
        cb1 = 1'b1; tick();
        chk("R11 release on cb1", cb2_out, 1'b1);

        // R12 pulse mode on port B
        wr(2'b11, 8'h2C);
        tick();
        wr(2'b10, 8'hAA);
        chk("R12 pulse start", cb2_out, 1'b0);
        for (int k = 1; k < P; k++) begin
            tick();
            chk("R12 pulse held", cb2_out, 1'b0);
        end
        tick();
        chk("R12 pulse end", cb2_out, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule